// File: doc/BRIEF.md
# Parallel Sliding Sync-Word Correlator

This block searches a demodulated bitstream for a fixed, long sync word. The stream arrives as one L-bit parallel word per clock, with bit 0 of each word the earliest bit on the line. The block keeps the two most recent words in a 2L-bit window. Every cycle it scores each of the L possible bit offsets of the sync word inside that window at the same time. A score is the count of bit positions that agree with the sync word.

A pipelined adder tree reduces each offset's match bits to a score. A pipelined comparator tree then finds the highest score and the offset that produced it. The block outputs that score and offset together with a copy of the window, delayed so that all three describe the same cycle. Downstream logic compares the score against its own threshold and extracts the payload from the delayed window. An enable input freezes the whole datapath while the downstream logic is busy capturing a payload. A valid flag marks results that come from a completely filled window.

Top module: `sync_corr`

## Requirements
- R1: On each enabled clock edge, the input word loads into window bits 2L-1..L, and the previous contents of those bits move unchanged into bits L-1..0.
- R2: The score of offset i (0 <= i < L) is the number of positions j (0 <= j < L) where window bit i+j equals sync word bit j. Sync word bit j is the j-th transmitted bit.
- R3: The block outputs the highest score among the L offsets and that offset's index. With L=8, sync word 8'h8E (bits 0..7 = 0,1,1,1,0,0,0,1), lower window word 8'hE0 and upper word 8'h08, the output is score 8 at index 4.
- R4: When several offsets share the highest score, the lowest index is reported. An all-zero or all-one window with sync word 8'h8E gives score 4 at index 0.
- R5: The score, the index and the delayed window all appear D = 2*ceil(log2 L) enabled clock edges after the window register holds the contents they describe.
- R6: While the enable input is low, no register in the datapath changes, so the score, index and delayed window outputs hold their values.
- R7: The valid output is low after reset and after any enabled-low edge. It rises after D+2 consecutive enabled edges, and not before.
- R8: During reset, all outputs read zero.
- R9: A reported score never exceeds L. An offset starting at window bit 0 or at bit L-1 is found with a full score of L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Enable; low freezes the datapath and clears valid |
| din | input | L | Parallel input word, bit 0 earliest |
| best_score | output | ceil(log2(L+1)) | Highest match count |
| best_idx | output | ceil(log2 L) | Offset of the highest match count |
| win_dly | output | 2L | Window contents aligned with the score and index |
| res_vld | output | 1 | Result comes from a fully filled window |

## Verification
The hardest cases to reach are those where the sync word straddles the two window halves at a chosen offset: the example offset 4, and the two extremes, offset 0 and offset L-1. To reach each one, the stimulus writes a pair of words computed from the sync word so that the window holds the word at exactly that offset when the second word lands. It then checks the result exactly D edges later. Tie-breaking is driven by uniform windows, where every offset scores the same. Random runs with enable dropped at random, and a behavioural queue model compared every cycle, cover the freeze and the refill of the valid flag.

// File: rtl/sync_corr_pkg.sv
package sync_corr_pkg;
  // number of pairwise levels needed to reduce n leaves to one
  function automatic int tree_lvls(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sync_window.sv
module sync_window #(
  parameter int L = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [L-1:0]   din,
  output logic [2*L-1:0] win,
  output logic           full
);
  logic [2*L-1:0] win_q, win_d;
  logic [1:0]     fill_q, fill_d;

  always_comb begin
    win_d  = win_q;
    fill_d = 2'd0;
    if (en) begin
      win_d  = {din, win_q[2*L-1:L]};
      fill_d = (fill_q == 2'd2) ? 2'd2 : fill_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= 2'd0;
    end else begin
      win_q  <= win_d;
      fill_q <= fill_d;
    end
  end

  assign win  = win_q;
  assign full = (fill_q == 2'd2);
endmodule

// File: rtl/sync_match_tree.sv
module sync_match_tree
  import sync_corr_pkg::*;
#(
  parameter int           W   = 8,
  parameter logic [W-1:0] PAT = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [W-1:0]               seg,
  output logic [$clog2(W+1)-1:0]     score
);
  localparam int LV = tree_lvls(W);
  localparam int P  = 1 << LV;
  localparam int SW = $clog2(W+1);

  logic [SW-1:0] leaf [P];
  logic [SW-1:0] q    [LV+1][P];
  logic [SW-1:0] d    [LV+1][P];

  for (genvar j = 0; j < P; j++) begin : g_leaf
    if (j < W) begin : g_bit
      assign leaf[j] = {{(SW-1){1'b0}}, ~(seg[j] ^ PAT[j])};
    end else begin : g_pad
      assign leaf[j] = '0;
    end
  end

  always_comb begin
    for (int lv = 0; lv <= LV; lv++)
      for (int n = 0; n < P; n++)
        d[lv][n] = '0;
    for (int lv = 1; lv <= LV; lv++)
      for (int n = 0; n < (P >> lv); n++)
        d[lv][n] = (lv == 1) ? leaf[2*n] + leaf[2*n+1]
                             : q[lv-1][2*n] + q[lv-1][2*n+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int lv = 0; lv <= LV; lv++)
        for (int n = 0; n < P; n++)
          q[lv][n] <= '0;
    end else if (en) begin
      for (int lv = 0; lv <= LV; lv++)
        for (int n = 0; n < P; n++)
          q[lv][n] <= d[lv][n];
    end
  end

  assign score = q[LV][0];
endmodule

// File: rtl/sync_argmax_tree.sv
module sync_argmax_tree
  import sync_corr_pkg::*;
#(
  parameter int L  = 8,
  parameter int SW = 4,
  parameter int IW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [L-1:0][SW-1:0]  scores,
  output logic [SW-1:0]         top_score,
  output logic [IW-1:0]         top_idx
);
  localparam int LV = tree_lvls(L);
  localparam int P  = 1 << LV;

  logic [SW-1:0] lsc [P];
  logic [IW-1:0] lix [P];
  logic [SW-1:0] sq [LV+1][P];
  logic [SW-1:0] sd [LV+1][P];
  logic [IW-1:0] iq [LV+1][P];
  logic [IW-1:0] id [LV+1][P];

  for (genvar j = 0; j < P; j++) begin : g_leaf
    if (j < L) begin : g_real
      assign lsc[j] = scores[j];
      assign lix[j] = IW'(j);
    end else begin : g_pad
      assign lsc[j] = '0;
      assign lix[j] = '0;
    end
  end

  always_comb begin
    logic [SW-1:0] sa, sb;
    logic [IW-1:0] ia, ib;
    for (int lv = 0; lv <= LV; lv++)
      for (int n = 0; n < P; n++) begin
        sd[lv][n] = '0;
        id[lv][n] = '0;
      end
    for (int lv = 1; lv <= LV; lv++)
      for (int n = 0; n < (P >> lv); n++) begin
        sa = (lv == 1) ? lsc[2*n]   : sq[lv-1][2*n];
        sb = (lv == 1) ? lsc[2*n+1] : sq[lv-1][2*n+1];
        ia = (lv == 1) ? lix[2*n]   : iq[lv-1][2*n];
        ib = (lv == 1) ? lix[2*n+1] : iq[lv-1][2*n+1];
        // strict compare: the lower-index side wins a tie
        if (sb > sa) begin
          sd[lv][n] = sb;
          id[lv][n] = ib;
        end else begin
          sd[lv][n] = sa;
          id[lv][n] = ia;
        end
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int lv = 0; lv <= LV; lv++)
        for (int n = 0; n < P; n++) begin
          sq[lv][n] <= '0;
          iq[lv][n] <= '0;
        end
    end else if (en) begin
      for (int lv = 0; lv <= LV; lv++)
        for (int n = 0; n < P; n++) begin
          sq[lv][n] <= sd[lv][n];
          iq[lv][n] <= id[lv][n];
        end
    end
  end

  assign top_score = sq[LV][0];
  assign top_idx   = iq[LV][0];
endmodule

// File: rtl/sync_win_delay.sv
module sync_win_delay #(
  parameter int WW = 16,
  parameter int D  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [WW-1:0] din,
  output logic [WW-1:0] dout
);
  logic [WW-1:0] st_q [D];
  logic [WW-1:0] st_d [D];

  always_comb begin
    st_d[0] = din;
    for (int s = 1; s < D; s++) st_d[s] = st_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < D; s++) st_q[s] <= '0;
    end else if (en) begin
      for (int s = 0; s < D; s++) st_q[s] <= st_d[s];
    end
  end

  assign dout = st_q[D-1];
endmodule

// File: rtl/sync_corr.sv
module sync_corr
  import sync_corr_pkg::*;
#(
  parameter int           L         = 8,
  parameter logic [L-1:0] SYNC_WORD = 8'h8E,
  localparam int          SW        = $clog2(L+1),
  localparam int          IW        = $clog2(L)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [L-1:0]   din,
  output logic [SW-1:0]  best_score,
  output logic [IW-1:0]  best_idx,
  output logic [2*L-1:0] win_dly,
  output logic           res_vld
);
  localparam int LV = tree_lvls(L);
  localparam int D  = 2 * LV;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic [2*L-1:0]       win;
  logic                 win_full;
  logic [L-1:0][SW-1:0] scores;

  sync_window #(.L(L)) u_win (
    .clk(clk), .rst_n(srst_n), .en(en), .din(din),
    .win(win), .full(win_full)
  );

  for (genvar i = 0; i < L; i++) begin : g_cand
    sync_match_tree #(.W(L), .PAT(SYNC_WORD)) u_mt (
      .clk(clk), .rst_n(srst_n), .en(en),
      .seg(win[i+L-1:i]), .score(scores[i])
    );
  end

  sync_argmax_tree #(.L(L), .SW(SW), .IW(IW)) u_max (
    .clk(clk), .rst_n(srst_n), .en(en), .scores(scores),
    .top_score(best_score), .top_idx(best_idx)
  );

  sync_win_delay #(.WW(2*L), .D(D)) u_dly (
    .clk(clk), .rst_n(srst_n), .en(en), .din(win), .dout(win_dly)
  );

  // valid flag travels with the data; cleared whenever enable drops
  logic [D-1:0] vld_q, vld_d;
  always_comb begin
    vld_d = '0;
    if (en) vld_d = {vld_q[D-2:0], win_full};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) vld_q <= '0;
    else         vld_q <= vld_d;
  end

  assign res_vld = vld_q[D-1];
endmodule

// File: rtl/sync_corr_chk.sv
module sync_corr_chk #(
  parameter int L  = 8,
  parameter int SW = 4,
  parameter int IW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic [SW-1:0]  best_score,
  input logic [IW-1:0]  best_idx,
  input logic [2*L-1:0] win_dly,
  input logic           res_vld
);
  // R6
  frozen_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(best_score) && $stable(best_idx) && $stable(win_dly)));

  // R7
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !res_vld);

  // R7
  vld_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(en));

  // R9
  score_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    best_score <= SW'(L));

  // R1
  half_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && $past(res_vld)) |-> (win_dly[L-1:0] == $past(win_dly[2*L-1:L])));
endmodule

bind sync_corr sync_corr_chk #(.L(L), .SW(SW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en),
  .best_score(best_score), .best_idx(best_idx),
  .win_dly(win_dly), .res_vld(res_vld)
);

// File: tb/test_sync_corr.sv
`timescale 1ns/1ps
module test_sync_corr;
  localparam int L  = 8;
  localparam logic [L-1:0] PAT = 8'h8E;
  localparam int SW = 4;
  localparam int IW = 3;
  localparam int D  = 6;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           en;
  logic [L-1:0]   din;
  logic [SW-1:0]  best_score;
  logic [IW-1:0]  best_idx;
  logic [2*L-1:0] win_dly;
  logic           res_vld;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  sync_corr #(.L(L), .SYNC_WORD(PAT)) i_sync_corr (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din),
    .best_score(best_score), .best_idx(best_idx),
    .win_dly(win_dly), .res_vld(res_vld)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: window, fill count and a D-deep result queue
  logic [2*L-1:0] mw;
  int             mfill;
  int             ps [D];
  int             pi [D];
  logic [2*L-1:0] pw [D];
  bit             pv [D];

  function automatic void best_of(input logic [2*L-1:0] w, output int bs, output int bi);
    bs = -1; bi = 0;
    for (int i = 0; i < L; i++) begin
      int s = 0;
      for (int j = 0; j < L; j++) if (w[i+j] == PAT[j]) s++;
      if (s > bs) begin bs = s; bi = i; end
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mw = '0; mfill = 0;
      for (int s = 0; s < D; s++) begin ps[s] = 0; pi[s] = 0; pw[s] = '0; pv[s] = 0; end
    end else if (en) begin
      int bs, bi;
      for (int s = D-1; s > 0; s--) begin
        ps[s] = ps[s-1]; pi[s] = pi[s-1]; pw[s] = pw[s-1]; pv[s] = pv[s-1];
      end
      best_of(mw, bs, bi);
      ps[0] = bs; pi[0] = bi; pw[0] = mw; pv[0] = (mfill == 2);
      mw = {din, mw[2*L-1:L]};
      mfill = (mfill == 2) ? 2 : mfill + 1;
    end else begin
      for (int s = 0; s < D; s++) pv[s] = 0;
      mfill = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model score", int'(best_score), ps[D-1]);
      chk("R3 model index", int'(best_idx), pi[D-1]);
      chk("R1 model window", int'(win_dly), int'(pw[D-1]));
      chk("R7 model valid", int'(res_vld), int'(pv[D-1]));
    end
  end

  task automatic step(input logic e, input logic [L-1:0] w);
    en = e; din = w;
    @(posedge clk); @(negedge clk);
  endtask

  // feed two words, then wait D enabled edges and check the result
  task automatic pair_check(input logic [L-1:0] lo, input logic [L-1:0] hi,
                            input int exp_s, input int exp_i, input string tag);
    step(1'b1, lo);
    step(1'b1, hi);
    for (int n = 0; n < D; n++) step(1'b1, L'($urandom));
    chk({tag, " score"}, int'(best_score), exp_s);
    chk({tag, " index"}, int'(best_idx), exp_i);
    chk({tag, " window"}, int'(win_dly), int'({hi, lo}));
  endtask

  initial begin
    int seen;
    logic [SW-1:0] hs;
    logic [IW-1:0] hi_;
    logic [2*L-1:0] hw;
    rst_n = 1'b0; en = 1'b0; din = '0;
    void'($urandom(7));
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset score", int'(best_score), 0);
    chk("R8 reset index", int'(best_idx), 0);
    chk("R8 reset window", int'(win_dly), 0);
    chk("R8 reset valid", int'(res_vld), 0);
    rst_n = 1'b1;
    repeat (4) step(1'b0, '0);

    // R3 offset 4 example, with R7 valid timing from enable
    step(1'b1, 8'hE0);
    step(1'b1, 8'h08);
    seen = 0;
    for (int n = 0; n < D; n++) begin
      if (n == D-1) chk("R7 valid before D+2 edges", int'(res_vld), 0);
      step(1'b1, L'($urandom));
    end
    chk("R3 offset4 score", int'(best_score), 8);
    chk("R3 offset4 index", int'(best_idx), 4);
    chk("R7 valid after D+2 edges", int'(res_vld), 1);

    pair_check(8'h8E, 8'h5A, 8, 0, "R9 offset0");
    pair_check(8'h00, 8'h47, 8, 7, "R9 offset7");
    pair_check(8'h00, 8'h00, 4, 0, "R4 tie zeros");
    pair_check(8'hFF, 8'hFF, 4, 0, "R4 tie ones");
    pair_check(8'hE0, 8'h08, 8, 4, "R5 latency");

    // R6 freeze
    hs = best_score; hi_ = best_idx; hw = win_dly;
    for (int n = 0; n < 5; n++) step(1'b0, L'($urandom));
    chk("R6 hold score", int'(best_score), int'(hs));
    chk("R6 hold index", int'(best_idx), int'(hi_));
    chk("R6 hold window", int'(win_dly), int'(hw));
    chk("R7 valid low while off", int'(res_vld), 0);

    // random traffic with embedded sync words and enable gaps
    for (int n = 0; n < 400; n++) begin
      logic [L-1:0] w = L'($urandom);
      if (($urandom % 16) == 0) w = PAT;
      step(($urandom % 10) != 0, w);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule